// File: doc/BRIEF.md
# Filtered Supply-Monitor Interrupt Generator

This block turns a comparator level, already brought into the clock domain, into a clean supply-state signal and an interrupt request. The comparator output states whether the supply is above its threshold. A digital filter samples it at a rate picked from the low-speed oscillator clock divided by 1, 2, 4 or 8. Each move of the filtered level, up or down, can set a sticky detection flag and emit a single-cycle interrupt pulse.

The flag holds off further requests until software writes zero to it through a clear strobe. A global detection enable parks the whole path in a safe state when it is low: the filtered level reads high and the flag reads zero. The circuit that routes the request to a vector lies outside this block.

Top module: `supply_mon_irq`

## Requirements
- R1: The filter takes a sample every 1, 2, 4 or 8 clock cycles for select codes 0, 1, 2 and 3. After reset the first sample is taken on the first clock edge.
- R2: A new divider select takes effect only at the end of the sampling period in progress, so no sampling period is cut short.
- R3: The filtered level moves to a new value only on a sample that matches the sample before it. A single differing sample leaves the filtered level unchanged. The filtered level changes only on a sampling edge.
- R4: When the filtered level changes in either direction while the flag is 0 and the interrupt enable is 1, the flag becomes 1 and the interrupt output is high for exactly one cycle. Both happen in the same cycle as the filtered level changes.
- R5: While the flag is 1 and no clear strobe is applied, no interrupt pulse is produced.
- R6: The clear strobe sets the flag to 0 on the next cycle when no qualifying change occurs in the same cycle. The strobe has no effect on the filtered level.
- R7: When the clear strobe and a qualifying level change occur in the same cycle, the flag stays 1 and the interrupt pulse is issued.
- R8: When the interrupt enable is 0, no interrupt pulse is issued and the flag is not set.
- R9: When detection is disabled, the flag is held at 0, the filtered level is held high, the interrupt output is held low, and the sample register is preset high.
- R10: After reset the filtered level is 1, the flag is 0, the interrupt output is 0 and the divider count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Global detection enable |
| irq_en | input | 1 | Interrupt request enable |
| div_sel | input | 2 | Sampling divider select (0 to 3 gives divide by 1 to 8) |
| cmp_lvl | input | 1 | Synchronised comparator level, 1 = supply above threshold |
| flag_wr0 | input | 1 | Software write-zero strobe for the flag |
| filt_lvl | output | 1 | Filtered supply level |
| det_flag | output | 1 | Sticky detection flag |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
A wrong divider count or a stale select shows at the ports as a filtered level that moves one or more clock cycles early or late. It appears within one sampling period of at most eight cycles. A corrupt sample register shows up as an accepted glitch or a missed change at the next sampling edge. A flag stuck high or low shows at once as an interrupt that is missing or extra. The reference model compares all three outputs on every cycle, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int SEL_W = 2;

  // Sampling period in clock cycles for a select code
  function automatic int unsigned period_of(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // Filter acceptance: new level accepted when two successive samples agree
  function automatic logic accept(input logic cur, input logic prev_s);
    return cur == prev_s;
  endfunction
endpackage

// File: rtl/smi_divider.sv
module smi_divider
  import smi_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int CNT_W = (1 << SW) - 1;

  logic [CNT_W-1:0] cnt;
  logic [SW-1:0]    sel_q;
  logic [CNT_W:0]   last;

  always_comb begin
    last = (CNT_W+1)'(period_of(sel_q) - 1);
    tick = ({1'b0, cnt} == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= '0;
    end else if (tick) begin
      cnt   <= '0;
      sel_q <= sel;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smi_filter.sv
module smi_filter
  import smi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic cmp,
  output logic filt,
  output logic chg
);
  logic samp;

  assign chg = en && tick && accept(cmp, samp) && (cmp != filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 1'b1;
      filt <= 1'b1;
    end else if (!en) begin
      samp <= 1'b1;
      filt <= 1'b1;
    end else if (tick) begin
      samp <= cmp;
      if (accept(cmp, samp)) filt <= cmp;
    end
  end
endmodule

// File: rtl/smi_flag.sv
module smi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic chg,
  input  logic irq_en,
  input  logic wr0,
  output logic flag,
  output logic irq,
  output logic set_ev
);
  assign set_ev = en && chg && irq_en && (!flag || wr0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else if (!en) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= set_ev;
      if (set_ev)   flag <= 1'b1;
      else if (wr0) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/supply_mon_irq.sv
module supply_mon_irq
  import smi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             irq_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             cmp_lvl,
  input  logic             flag_wr0,
  output logic             filt_lvl,
  output logic             det_flag,
  output logic             irq_pulse
);
  logic samp_tick;
  logic lvl_chg;
  logic flag_set;

  smi_divider #(.SW(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(samp_tick)
  );

  smi_filter u_filt (
    .clk(clk), .rst_n(rst_n), .en(det_en), .tick(samp_tick),
    .cmp(cmp_lvl), .filt(filt_lvl), .chg(lvl_chg)
  );

  smi_flag u_flag (
    .clk(clk), .rst_n(rst_n), .en(det_en), .chg(lvl_chg), .irq_en(irq_en),
    .wr0(flag_wr0), .flag(det_flag), .irq(irq_pulse), .set_ev(flag_set)
  );
endmodule

// File: rtl/smi_checker.sv
module smi_checker (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic irq_en,
  input logic flag_wr0,
  input logic filt_lvl,
  input logic det_flag,
  input logic irq_pulse,
  input logic tick,
  input logic chg
);
  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> det_flag);
  assert_flag_rise_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> irq_pulse);
  assert_irq_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_flag_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !flag_wr0) |=> !irq_pulse);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr0 && !chg) |=> !det_flag);
  assert_no_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr0 && chg && irq_en && det_en) |=> (det_flag && irq_pulse));
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_pulse);
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!det_flag && filt_lvl && !irq_pulse));
  assert_filt_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !tick) |=> $stable(filt_lvl));
endmodule

bind supply_mon_irq smi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .irq_en(irq_en),
  .flag_wr0(flag_wr0), .filt_lvl(filt_lvl), .det_flag(det_flag),
  .irq_pulse(irq_pulse), .tick(samp_tick), .chg(lvl_chg)
);

// File: tb/test_supply_mon_irq.sv
module test_supply_mon_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_en = 1'b0, irq_en = 1'b0, cmp_lvl = 1'b1, flag_wr0 = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       filt_lvl, det_flag, irq_pulse;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R10";

  // behavioural reference state
  int m_cnt, m_per, m_samp, m_filt, m_flag, m_irq;

  always #2 clk = ~clk;

  supply_mon_irq i_supply_mon_irq (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .irq_en(irq_en),
    .div_sel(div_sel), .cmp_lvl(cmp_lvl), .flag_wr0(flag_wr0),
    .filt_lvl(filt_lvl), .det_flag(det_flag), .irq_pulse(irq_pulse)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 1; m_samp = 1; m_filt = 1; m_flag = 0; m_irq = 0;
    end else begin
      bit sample_now, moved, fire;
      sample_now = (m_cnt + 1 == m_per);
      if (sample_now) begin m_cnt = 0; m_per = 2 ** div_sel; end
      else m_cnt++;
      if (!det_en) begin
        m_samp = 1; m_filt = 1; m_flag = 0; m_irq = 0;
      end else begin
        moved = sample_now && (int'(cmp_lvl) == m_samp) && (int'(cmp_lvl) != m_filt);
        fire  = moved && irq_en && (m_flag == 0 || flag_wr0);
        if (sample_now) begin
          if (int'(cmp_lvl) == m_samp) m_filt = cmp_lvl;
          m_samp = cmp_lvl;
        end
        m_irq = fire;
        if (fire) m_flag = 1;
        else if (flag_wr0) m_flag = 0;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(cur_req, "filt_lvl", filt_lvl, m_filt);
    check(cur_req, "det_flag", det_flag, m_flag);
    check(cur_req, "irq_pulse", irq_pulse, m_irq);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    check("R10", "reset filt", filt_lvl, 1);
    check("R10", "reset flag", det_flag, 0);
    check("R10", "reset irq", irq_pulse, 0);
    rst_n = 1'b1;
    det_en = 1'b1; irq_en = 1'b1;
    // R1: each divide ratio, steady toggles with clears
    for (int s = 0; s < 4; s++) begin
      cur_req = "R1";
      div_sel = 2'(s);
      for (int k = 0; k < 4; k++) begin
        cmp_lvl = ~cmp_lvl; cyc(20);
        flag_wr0 = 1'b1; cyc(1); flag_wr0 = 1'b0; cyc(3);
      end
    end
    // R2: select changes mid-period
    cur_req = "R2";
    for (int k = 0; k < 12; k++) begin
      div_sel = 2'(k % 4); cyc(3 + k % 5);
      cmp_lvl = ~cmp_lvl; cyc(17);
      flag_wr0 = 1'b1; cyc(1); flag_wr0 = 1'b0;
    end
    // R3: single-cycle glitches at several rates
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      div_sel = 2'(s); cyc(10);
      for (int k = 0; k < 10; k++) begin
        cmp_lvl = ~cmp_lvl; cyc(1); cmp_lvl = ~cmp_lvl; cyc(3 + k);
        flag_wr0 = 1'b1; cyc(1); flag_wr0 = 1'b0;
      end
    end
    // R4/R5: changes without clearing, then with
    cur_req = "R4"; div_sel = 2'd1; cyc(4);
    cmp_lvl = 1'b0; cyc(12);
    cur_req = "R5";
    cmp_lvl = 1'b1; cyc(12); cmp_lvl = 1'b0; cyc(12);
    // R6: clear with steady input, filt untouched
    cur_req = "R6";
    flag_wr0 = 1'b1; cyc(2); flag_wr0 = 1'b0; cyc(6);
    // R7: clear held while level toggles, so clear meets events
    cur_req = "R7"; div_sel = 2'd0;
    flag_wr0 = 1'b1; cmp_lvl = 1'b1; cyc(1); flag_wr0 = 1'b0; cyc(5);
    for (int k = 0; k < 8; k++) begin
      flag_wr0 = 1'b1; cmp_lvl = ~cmp_lvl; cyc(6);
    end
    flag_wr0 = 1'b0;
    // R8: interrupts masked
    cur_req = "R8"; irq_en = 1'b0; flag_wr0 = 1'b1; cyc(1); flag_wr0 = 1'b0;
    for (int k = 0; k < 6; k++) begin cmp_lvl = ~cmp_lvl; cyc(8); end
    irq_en = 1'b1;
    // R9: detection disabled while input low and toggling
    cur_req = "R9"; cmp_lvl = 1'b0; cyc(10); det_en = 1'b0;
    for (int k = 0; k < 6; k++) begin cmp_lvl = ~cmp_lvl; cyc(7); end
    cmp_lvl = 1'b0; det_en = 1'b1; cyc(20);
    // mixed random stretch
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      cmp_lvl  = ($urandom % 6 == 0) ? ~cmp_lvl : cmp_lvl;
      flag_wr0 = ($urandom % 9 == 0);
      irq_en   = ($urandom % 20 != 0);
      det_en   = ($urandom % 150 != 0);
      if ($urandom % 100 == 0) div_sel = 2'($urandom);
      cyc(1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule